// File: doc/BRIEF.md
# Tiered Current Fault Timer

This block qualifies current-fault comparator flags over time and turns them into latched protection states. Three discharge flags of rising severity (a moderate overcurrent, a heavy overcurrent and a short) each run their own detection timer in parallel. Whichever timer completes first latches the discharge inhibit and records its tier in a cause code. A fourth flag, for charge overcurrent, has its own detection timer and its own latched charge inhibit. Both latched states clear only after a release delay during which their flags stay clear.

All timers count a one-microsecond timebase tick, not clock cycles. The two overcurrent tiers take their delays as a base multiplied by a programmable scale value. In a circuit this scale stands in for an external timing capacitor. The short tier and all release delays are fixed by parameters. The block sits between the analog comparators and the FET drive logic.

Top module: `cur_fault_timer`

## Requirements
- R1: During and right after reset, discharge inhibit, charge inhibit and the cause code are all 0.
- R2: A discharge tier whose flag stays high sets the discharge inhibit at the clock edge of the tick that completes its delay. It does not set it on any earlier tick, and only ticks advance the count.
- R3: The cause code reads 0 when there is no fault, 1 for the level-1 tier, 2 for the level-2 tier and 3 for the short tier. It is non-zero exactly while the discharge inhibit is high.
- R4: When several tiers are pending, the first one to complete its delay sets the fault, and the cause code names that tier.
- R5: Once the discharge flags have all been clear for the release delay in ticks, the discharge inhibit and the cause code return to 0.
- R6: If any discharge flag rises during the release wait, the release count starts over from zero.
- R7: If a tier's flag drops before its delay completes, that tier's count is lost. A later assertion needs the full delay again.
- R8: If tiers complete on the same tick, the short tier wins over level 2, and level 2 wins over level 1.
- R9: A charge flag held for the charge detection delay sets the charge inhibit. It leaves the discharge inhibit and the cause code untouched.
- R10: The charge inhibit clears after the charge flag has been clear for the charge release delay. A reassertion of the flag restarts that wait.
- R11: The level-1 and level-2 delays equal their base tick counts times the scale input. A scale of 0 acts as 1, and the short delay does not scale.
- R12: While the discharge inhibit is latched, new discharge flags do not change the cause code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | One-cycle timebase pulse, nominally once per microsecond |
| dsg_lvl1_i | input | 1 | Level-1 discharge overcurrent comparator flag |
| dsg_lvl2_i | input | 1 | Level-2 discharge overcurrent comparator flag |
| dsg_short_i | input | 1 | Short-circuit comparator flag |
| chg_oc_i | input | 1 | Charge overcurrent comparator flag |
| delay_scale_i | input | SCALE_W | Multiplier for the level-1 and level-2 delays |
| dsg_inhibit_o | output | 1 | Latched discharge fault, blocks discharge |
| chg_inhibit_o | output | 1 | Latched charge fault, blocks charge |
| fault_cause_o | output | 2 | Tier that set the discharge fault |

## Verification
The hardest case to reach from the ports is two tiers completing on the very same tick. This only happens when the scaled level-2 delay equals the fixed short delay. The stimulus picks a scale that makes the two equal, then raises both flags at the same falling edge. Reaching a restarted release is also awkward, because a flag must rise after part of the release wait has passed. The stimulus counts ticks to a point short of the delay, pulses a flag, and then checks that the full release delay is needed again.

// File: rtl/cft_pkg.sv
package cft_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_LVL1  = 2'd1,
    CAUSE_LVL2  = 2'd2,
    CAUSE_SHORT = 2'd3
  } cause_t;

  // a scale of zero behaves as one
  function automatic int unsigned eff_scale(input int unsigned s);
    return (s == 0) ? 1 : s;
  endfunction

  function automatic int unsigned tier_limit(input int unsigned base, input int unsigned s);
    return base * eff_scale(s);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cft_tick_window.sv
// Counts timebase ticks while run is high; done pulses on the tick that
// completes limit ticks. Dropping run discards the count.
module cft_tick_window #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit};
  assign done = run & tick & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (done)     cnt <= '0;
    else if (tick)     cnt <= cnt + 1'b1;
  end

  // R7: an idle window starts from zero
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R2: only ticks advance the count
  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/cft_cause_pick.sv
// Fixed-priority choice among tiers completing on the same tick.
module cft_cause_pick
  import cft_pkg::*;
(
  input  logic [2:0] done,
  output cause_t     pick,
  output logic       any
);
  assign any = |done;

  always_comb begin
    if (done[2])      pick = CAUSE_SHORT;
    else if (done[1]) pick = CAUSE_LVL2;
    else if (done[0]) pick = CAUSE_LVL1;
    else              pick = CAUSE_NONE;
  end

  // R8: a reported pick always comes from a completing tier
  p_pick_valid_r8: assert final ((pick == CAUSE_NONE) == !any);
endmodule

// File: rtl/cur_fault_timer.sv
module cur_fault_timer
  import cft_pkg::*;
#(
  parameter int unsigned SCALE_W     = 4,
  parameter int unsigned BASE_L1_US  = 100000,
  parameter int unsigned BASE_L2_US  = 10000,
  parameter int unsigned SHORT_US    = 350,
  parameter int unsigned DSG_REL_US  = 1024000,
  parameter int unsigned CHG_DET_US  = 1024000,
  parameter int unsigned CHG_REL_US  = 128000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_us_i,
  input  logic               dsg_lvl1_i,
  input  logic               dsg_lvl2_i,
  input  logic               dsg_short_i,
  input  logic               chg_oc_i,
  input  logic [SCALE_W-1:0] delay_scale_i,
  output logic               dsg_inhibit_o,
  output logic               chg_inhibit_o,
  output logic [1:0]         fault_cause_o
);
  localparam int unsigned SCALE_MAX = (1 << SCALE_W) - 1;
  localparam int unsigned PEAK = umax(umax(BASE_L1_US * SCALE_MAX, BASE_L2_US * SCALE_MAX),
                                      umax(umax(SHORT_US, DSG_REL_US), umax(CHG_DET_US, CHG_REL_US)));
  localparam int CNT_W = $clog2(PEAK + 1);

  logic [2:0]       dsg_flag;
  logic [CNT_W-1:0] tier_lim [3];
  logic [2:0]       tier_done;
  int unsigned      scale_u;
  cause_t           pick;
  logic             any_done;
  logic             dsg_fault, chg_fault;
  cause_t           cause_q;
  logic             dsg_quiet, dsg_rel_done, chg_det_done, chg_rel_done;

  assign dsg_flag  = {dsg_short_i, dsg_lvl2_i, dsg_lvl1_i};
  assign dsg_quiet = (dsg_flag == 3'b000);
  assign scale_u   = 32'(delay_scale_i);

  assign tier_lim[0] = CNT_W'(tier_limit(BASE_L1_US, scale_u));
  assign tier_lim[1] = CNT_W'(tier_limit(BASE_L2_US, scale_u));
  assign tier_lim[2] = CNT_W'(SHORT_US);

  for (genvar t = 0; t < 3; t++) begin : g_tier
    cft_tick_window #(.CNT_W(CNT_W)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_us_i),
      .run   (dsg_flag[t] & ~dsg_fault),
      .limit (tier_lim[t]),
      .done  (tier_done[t])
    );
  end

  cft_cause_pick u_pick (
    .done (tier_done),
    .pick (pick),
    .any  (any_done)
  );

  cft_tick_window #(.CNT_W(CNT_W)) u_dsg_rel (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_us_i),
    .run   (dsg_fault & dsg_quiet),
    .limit (CNT_W'(DSG_REL_US)),
    .done  (dsg_rel_done)
  );

  cft_tick_window #(.CNT_W(CNT_W)) u_chg_det (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_us_i),
    .run   (chg_oc_i & ~chg_fault),
    .limit (CNT_W'(CHG_DET_US)),
    .done  (chg_det_done)
  );

  cft_tick_window #(.CNT_W(CNT_W)) u_chg_rel (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_us_i),
    .run   (chg_fault & ~chg_oc_i),
    .limit (CNT_W'(CHG_REL_US)),
    .done  (chg_rel_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsg_fault <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else if (!dsg_fault && any_done) begin
      dsg_fault <= 1'b1;
      cause_q   <= pick;
    end else if (dsg_fault && dsg_rel_done) begin
      dsg_fault <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        chg_fault <= 1'b0;
    else if (!chg_fault && chg_det_done) chg_fault <= 1'b1;
    else if (chg_fault && chg_rel_done)  chg_fault <= 1'b0;
  end

  assign dsg_inhibit_o = dsg_fault;
  assign chg_inhibit_o = chg_fault;
  assign fault_cause_o = cause_q;

  p_cause_tracks_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dsg_fault == (cause_q != CAUSE_NONE));

  p_set_from_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsg_fault) |-> $past(dsg_flag != 3'b000));

  p_clear_when_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsg_fault) |-> $past(dsg_quiet));

  p_cause_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dsg_fault && $past(dsg_fault)) |-> (cause_q == $past(cause_q)));

  p_chg_from_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_fault) |-> $past(chg_oc_i));
endmodule

// File: tb/cur_fault_timer_test.sv
module cur_fault_timer_test;
  localparam int SW = 3;
  localparam int B_L1 = 6, B_L2 = 2, B_SH = 4, B_DREL = 5, B_CDET = 8, B_CREL = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0;
  logic lvl1 = 1'b0, lvl2 = 1'b0, shrt = 1'b0, chg = 1'b0;
  logic [SW-1:0] scale = 1;
  logic dsg_o, chg_o;
  logic [1:0] cause_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { string req; logic dsg; logic chg; logic [1:0] cause; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  cur_fault_timer #(.SCALE_W(SW), .BASE_L1_US(B_L1), .BASE_L2_US(B_L2), .SHORT_US(B_SH),
    .DSG_REL_US(B_DREL), .CHG_DET_US(B_CDET), .CHG_REL_US(B_CREL)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us_i(tick_us), .dsg_lvl1_i(lvl1), .dsg_lvl2_i(lvl2),
    .dsg_short_i(shrt), .chg_oc_i(chg), .delay_scale_i(scale),
    .dsg_inhibit_o(dsg_o), .chg_inhibit_o(chg_o), .fault_cause_o(cause_o));

  // bench restatement of the scaled delay (R11)
  function automatic int lim(input int base, input int s);
    return base * ((s < 1) ? 1 : s);
  endfunction

  // tick every second cycle, changing on falling edges
  initial forever begin
    @(negedge clk);
    tick_us = rst_n ? ~tick_us : 1'b0;
  end

  task automatic step_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (tick_us !== 1'b1);
    end
    @(negedge clk);
  endtask

  task automatic expect_state(input string req, input logic d, input logic c, input logic [1:0] k);
    exp_t e;
    e.req = req; e.dsg = d; e.chg = c; e.cause = k;
    sb.push_back(e);
  endtask

  // monitor: compares queued expectations just after the falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (dsg_o !== e.dsg || chg_o !== e.chg || cause_o !== e.cause) begin
        errors++;
        $display("FAIL %s: got dsg=%b chg=%b cause=%0d expected dsg=%b chg=%b cause=%0d",
                 e.req, dsg_o, chg_o, cause_o, e.dsg, e.chg, e.cause);
      end
    end
  end

  task automatic release_all();
    lvl1 = 0; lvl2 = 0; shrt = 0;
    step_ticks(B_DREL);
    expect_state("R5", 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_state("R1", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    expect_state("R1", 0, 0, 0);

    // R2/R3/R11: level-1 with scale 2 completes at 12 ticks
    scale = 2; lvl1 = 1;
    step_ticks(lim(B_L1, 2) - 1);
    expect_state("R2", 0, 0, 0);
    step_ticks(1);
    expect_state("R2", 1, 0, 1);

    // R5/R6/R12: partial release, then a flag in fault, then restart
    lvl1 = 0;
    step_ticks(B_DREL - 1);
    expect_state("R5", 1, 0, 1);
    lvl2 = 1;
    step_ticks(20);
    expect_state("R12", 1, 0, 1);
    lvl2 = 0;
    step_ticks(B_DREL - 1);
    expect_state("R6", 1, 0, 1);
    step_ticks(1);
    expect_state("R5", 0, 0, 0);

    // R4: level-2 (4 ticks) beats level-1 (12 ticks)
    lvl1 = 1; lvl2 = 1;
    step_ticks(lim(B_L2, 2) - 1);
    expect_state("R4", 0, 0, 0);
    step_ticks(1);
    expect_state("R4", 1, 0, 2);
    release_all();

    // R4/R11: scale 3, short (4, unscaled) beats level-2 (6)
    scale = 3; lvl1 = 1; lvl2 = 1; shrt = 1;
    step_ticks(B_SH - 1);
    expect_state("R11", 0, 0, 0);
    step_ticks(1);
    expect_state("R4", 1, 0, 3);
    release_all();

    // R7: interrupted level-1 needs the full delay again
    scale = 1; lvl1 = 1;
    step_ticks(4);
    lvl1 = 0;
    step_ticks(1);
    lvl1 = 1;
    step_ticks(lim(B_L1, 1) - 1);
    expect_state("R7", 0, 0, 0);
    step_ticks(1);
    expect_state("R7", 1, 0, 1);
    release_all();

    // R8: scale 2 makes level-2 and short both 4 ticks
    scale = 2; lvl2 = 1; shrt = 1;
    step_ticks(B_SH);
    expect_state("R8", 1, 0, 3);
    release_all();

    // R11: scale 0 acts as 1 for level-2
    scale = 0; lvl2 = 1;
    step_ticks(lim(B_L2, 0) - 1);
    expect_state("R11", 0, 0, 0);
    step_ticks(1);
    expect_state("R11", 1, 0, 2);
    release_all();

    // R9/R10: charge detection and release with restart
    chg = 1;
    step_ticks(B_CDET - 1);
    expect_state("R9", 0, 0, 0);
    step_ticks(1);
    expect_state("R9", 0, 1, 0);
    chg = 0;
    step_ticks(B_CREL - 2);
    chg = 1;
    step_ticks(3);
    expect_state("R10", 0, 1, 0);
    chg = 0;
    step_ticks(B_CREL - 1);
    expect_state("R10", 0, 1, 0);
    step_ticks(1);
    expect_state("R10", 0, 0, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule